// File: doc/BRIEF.md
# Per-256-byte Hamming ECC generator

This block sits beside the byte path between a NAND flash and its host and folds every byte it accepts into a single-error-correcting Hamming parity. Parity is kept per block of 256 data bytes. When the last byte of a block is accepted, the parity is frozen into a 21-bit raw parity register, and the 24-bit stored form (the three spare-area bytes) is presented beside it. The byte counter then starts the next block by itself, so a whole page streams through with no software action between blocks.

The byte stream uses a valid/ready handshake. A byte moves on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high on every cycle except one where `ecc_clr` is asserted. A byte offered during a clear therefore waits, and is taken on a later cycle. Accepted bytes are folded into the parity only while `ecc_en` is high. Bytes that pass with `ecc_en` low leave the parity and the block count untouched.

To check a block that has been read back, the host presents the stored code it read from the spare area on `chk_code` with a one-cycle `chk_valid`. The block compares that code with the stored form of the most recently completed parity. It reports one of four outcomes: a clean block, a single flipped data bit together with its byte and bit position, a single flipped bit in the code bytes themselves, or damage it cannot correct.

Top module: `nand_hamming_ecc`

## Requirements
- R1: For byte index i (0..255) within a block, each index bit k has two line parities. The odd one is the XOR of all data bits of bytes with bit k of i equal to 1, and the even one covers bytes with that bit equal to 0. `raw_par[6+2k]` holds the even parity and `raw_par[7+2k]` the odd parity for k = 0..6. `raw_par[20]` holds the even parity of index bit 7, and the odd parity of index bit 7 is not kept.
- R2: For each bit position j within a byte, three bits m of j (m = 0..2) each have two column parities. `raw_par[2m+1]` is the XOR, over all 256 bytes, of the data bits whose position j has bit m equal to 1. `raw_par[2m]` covers the positions with bit m equal to 0.
- R3: `code_out` always equals the bitwise inverse of (`raw_par` shifted left by two), taken over 24 bits. Its first stored byte is bits [23:16], then [15:8], then [7:0]. With `raw_par` zero the value is 0xFFFFFF.
- R4: `blk_done` pulses for one cycle after the 256th accepted enabled byte of a block. `raw_par` changes at exactly that edge and holds at every other edge. The next block starts counting at index 0 without a clear.
- R5: A byte accepted while `ecc_en` is low changes neither the parity nor the byte count.
- R6: `ecc_clr` restarts the current block at index 0 with zero parity and drops `par_ready`. `in_ready` is low during the clear cycle, and the byte offered then is not accepted. `par_ready` rises together with `blk_done`.
- R7: One cycle after `chk_valid`, `chk_done` pulses. The comparison is made against `code_out` as it stood before that edge. When `chk_code` equals that code, `chk_status` is 0 (clean).
- R8: If the 24-bit difference lies entirely within bits [22:2] and each of the ten complete parity pairs differs in exactly one bit, `chk_status` is 1 (correctable). The data byte index is then taken from the odd line bits for index bits 0..6, with index bit 7 equal to the inverse of the difference at `raw_par[20]`. The bit position is taken from the odd column bits, and it appears on `err_byte`/`err_bit`. For every other outcome both location outputs are 0.
- R9: A difference of exactly one bit anywhere in the 24-bit code gives `chk_status` 2 (code-byte error).
- R10: Any other difference gives `chk_status` 3 (uncorrectable).
- R11: After reset `raw_par` is 0, `code_out` is 0xFFFFFF, `par_ready`, `blk_done` and `chk_done` are 0, and `in_ready` is 1.
- R12: When a compare request arrives in the same cycle as the last byte of a block, the compare uses the previous block's parity, and the new parity still appears with `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Fold accepted bytes into the parity |
| ecc_clr | input | 1 | Restart the current block, drop par_ready |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken (low only while clearing) |
| in_data | input | 8 | Stream byte |
| blk_done | output | 1 | One-cycle pulse when a block's parity is frozen |
| par_ready | output | 1 | A completed parity is available |
| raw_par | output | 21 | Raw parity: line parity [20:6], column parity [5:0] |
| code_out | output | 24 | Stored form of raw_par, byte 0 in [23:16] |
| chk_valid | input | 1 | Compare request |
| chk_code | input | 24 | Stored code read back from flash |
| chk_done | output | 1 | One-cycle pulse with the compare outcome |
| chk_status | output | 2 | 0 clean, 1 correctable, 2 code-byte error, 3 uncorrectable |
| err_byte | output | 8 | Byte index of a correctable error |
| err_bit | output | 3 | Bit position of a correctable error |

## Verification
The two functions that can fall in one cycle are the freezing of a block's parity and a compare request. The bench provokes this by raising `chk_valid` in the same cycle as the 256th byte. The code it presents is that of the previous block, so the verdict must be clean. At the same time, the scoreboard must still see the new block's parity with `blk_done`. A second meeting, a clear against an offered byte, is judged through `in_ready` and through the parity of the block that follows.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    CHK_CLEAN    = 2'd0,
    CHK_FIXABLE  = 2'd1,
    CHK_CODE_ERR = 2'd2,
    CHK_FATAL    = 2'd3
  } chk_status_e;

  localparam int COL_PAIRS = 3;
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter int IDX_W = 8,
  parameter int RAW_W = 2 * IDX_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       data,
  output logic             last,
  output logic             done,
  output logic [RAW_W-1:0] raw_q
);
  import hecc_pkg::*;

  logic [IDX_W-1:0]     cnt, lo, hi, lo_n, hi_n;
  logic [COL_PAIRS-1:0] clo, chi, clo_n, chi_n;
  logic                 byte_par;
  logic [RAW_W-1:0]     raw_n;

  assign last = &cnt;

  always_comb begin
    byte_par = ^data;
    for (int k = 0; k < IDX_W; k++) begin
      lo_n[k] = lo[k] ^ (byte_par & ~cnt[k]);
      hi_n[k] = hi[k] ^ (byte_par & cnt[k]);
    end
    clo_n = clo;
    chi_n = chi;
    for (int m = 0; m < COL_PAIRS; m++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> m) & 1) == 1) chi_n[m] = chi_n[m] ^ data[b];
        else                     clo_n[m] = clo_n[m] ^ data[b];
      end
    end
  end

  // column pairs in the low bits, line pairs above, top odd line bit dropped
  for (genvar m = 0; m < COL_PAIRS; m++) begin : g_col
    assign raw_n[2*m]   = clo_n[m];
    assign raw_n[2*m+1] = chi_n[m];
  end
  for (genvar k = 0; k < IDX_W - 1; k++) begin : g_line
    assign raw_n[2*COL_PAIRS+2*k]   = lo_n[k];
    assign raw_n[2*COL_PAIRS+2*k+1] = hi_n[k];
  end
  assign raw_n[RAW_W-1] = lo_n[IDX_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lo    <= '0;
      hi    <= '0;
      clo   <= '0;
      chi   <= '0;
      raw_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        cnt <= '0;
        lo  <= '0;
        hi  <= '0;
        clo <= '0;
        chi <= '0;
      end else if (take) begin
        cnt <= cnt + IDX_W'(1);
        if (last) begin
          raw_q <= raw_n;
          done  <= 1'b1;
          lo    <= '0;
          hi    <= '0;
          clo   <= '0;
          chi   <= '0;
        end else begin
          lo  <= lo_n;
          hi  <= hi_n;
          clo <= clo_n;
          chi <= chi_n;
        end
      end
    end
  end
endmodule

// File: rtl/hecc_encode.sv
module hecc_encode #(
  parameter int RAW_W  = 21,
  parameter int CODE_W = 24
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);
  assign code = ~(CODE_W'(raw) << 2);
endmodule

// File: rtl/hecc_check.sv
module hecc_check #(
  parameter int IDX_W  = 8,
  parameter int RAW_W  = 2 * IDX_W + 5,
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CODE_W-1:0] ref_code,
  output logic              done,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  err_byte,
  output logic [2:0]        err_bit
);
  import hecc_pkg::*;

  localparam int NPAIR = IDX_W - 1 + COL_PAIRS;
  localparam logic [CODE_W-1:0] FIELD = CODE_W'({RAW_W{1'b1}}) << 2;

  logic [CODE_W-1:0] syn;
  logic [RAW_W-1:0]  r;
  logic              outside, pairs_ok;
  logic [IDX_W-1:0]  loc_byte;
  logic [2:0]        loc_bit;
  chk_status_e       verdict;

  always_comb begin
    syn     = code_in ^ ref_code;
    r       = syn[2 +: RAW_W];
    outside = |(syn & ~FIELD);
    pairs_ok = 1'b1;
    for (int q = 0; q < NPAIR; q++) pairs_ok = pairs_ok & (r[2*q] ^ r[2*q+1]);
    for (int k = 0; k < IDX_W - 1; k++) loc_byte[k] = r[2*COL_PAIRS+2*k+1];
    loc_byte[IDX_W-1] = ~r[RAW_W-1];
    for (int m = 0; m < COL_PAIRS; m++) loc_bit[m] = r[2*m+1];
    if (syn == '0)                   verdict = CHK_CLEAN;
    else if ($countones(syn) == 1)   verdict = CHK_CODE_ERR;
    else if (!outside && pairs_ok)   verdict = CHK_FIXABLE;
    else                             verdict = CHK_FATAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      status   <= CHK_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      done <= valid;
      if (valid) begin
        status   <= verdict;
        err_byte <= (verdict == CHK_FIXABLE) ? loc_byte : '0;
        err_bit  <= (verdict == CHK_FIXABLE) ? loc_bit : '0;
      end
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int IDX_W = 8,
  localparam int RAW_W  = 2 * IDX_W + 5,
  localparam int CODE_W = ((RAW_W + 2 + 7) / 8) * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic              ecc_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              blk_done,
  output logic              par_ready,
  output logic [RAW_W-1:0]  raw_par,
  output logic [CODE_W-1:0] code_out,
  input  logic              chk_valid,
  input  logic [CODE_W-1:0] chk_code,
  output logic              chk_done,
  output logic [1:0]        chk_status,
  output logic [IDX_W-1:0]  err_byte,
  output logic [2:0]        err_bit
);
  logic take, last;

  assign in_ready = ~ecc_clr;
  assign take     = in_valid & in_ready & ecc_en;

  hecc_accum #(.IDX_W(IDX_W), .RAW_W(RAW_W)) u_accum (
    .clk(clk), .rst(rst), .clr(ecc_clr), .take(take), .data(in_data),
    .last(last), .done(blk_done), .raw_q(raw_par)
  );

  hecc_encode #(.RAW_W(RAW_W), .CODE_W(CODE_W)) u_encode (
    .raw(raw_par), .code(code_out)
  );

  hecc_check #(.IDX_W(IDX_W), .RAW_W(RAW_W), .CODE_W(CODE_W)) u_check (
    .clk(clk), .rst(rst), .valid(chk_valid), .code_in(chk_code),
    .ref_code(code_out), .done(chk_done), .status(chk_status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)               par_ready <= 1'b0;
    else if (ecc_clr)      par_ready <= 1'b0;
    else if (take && last) par_ready <= 1'b1;
  end
endmodule

// File: rtl/hecc_sva.sv
module hecc_sva #(
  parameter int IDX_W  = 8,
  parameter int RAW_W  = 21,
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ecc_en,
  input logic              ecc_clr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              blk_done,
  input logic              par_ready,
  input logic [RAW_W-1:0]  raw_par,
  input logic [CODE_W-1:0] code_out,
  input logic              chk_valid,
  input logic [CODE_W-1:0] chk_code,
  input logic              chk_done,
  input logic [1:0]        chk_status,
  input logic [IDX_W-1:0]  err_byte,
  input logic [2:0]        err_bit
);
  logic [IDX_W-1:0] seen;
  logic             took, last_take;

  assign took      = in_valid & in_ready & ecc_en;
  assign last_take = took & (&seen);

  always_ff @(posedge clk) begin
    if (rst || ecc_clr) seen <= '0;
    else if (took)      seen <= seen + IDX_W'(1);
  end

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    last_take |=> blk_done);
  // R4
  done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> $past(last_take));
  // R4
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_done |-> $stable(raw_par));
  // R6
  clear_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ecc_clr |=> !par_ready);
  // R6
  ready_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> par_ready);
  // R7
  chk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);
  // R7
  chk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(chk_valid));
  // R8
  location_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && chk_status != 2'd1) |-> (err_byte == '0 && err_bit == '0));
  // R9
  code_err_single_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && chk_status == 2'd2) |->
      ($countones($past(chk_code) ^ $past(code_out)) == 1));
endmodule

bind nand_hamming_ecc hecc_sva #(.IDX_W(IDX_W), .RAW_W(RAW_W), .CODE_W(CODE_W)) u_sva (
  .clk(clk), .rst(rst), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
  .in_valid(in_valid), .in_ready(in_ready), .blk_done(blk_done),
  .par_ready(par_ready), .raw_par(raw_par), .code_out(code_out),
  .chk_valid(chk_valid), .chk_code(chk_code), .chk_done(chk_done),
  .chk_status(chk_status), .err_byte(err_byte), .err_bit(err_bit)
);

// File: tb/nand_hamming_ecc_test.sv
`timescale 1ns/100ps
module nand_hamming_ecc_test;
  logic        clk = 1'b0;
  logic        rst, ecc_en, ecc_clr, in_valid, in_ready, chk_valid;
  logic [7:0]  in_data;
  logic        blk_done, par_ready, chk_done;
  logic [20:0] raw_par;
  logic [23:0] code_out, chk_code;
  logic [1:0]  chk_status;
  logic [7:0]  err_byte;
  logic [2:0]  err_bit;

  nand_hamming_ecc uut (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .blk_done(blk_done), .par_ready(par_ready), .raw_par(raw_par),
    .code_out(code_out), .chk_valid(chk_valid), .chk_code(chk_code),
    .chk_done(chk_done), .chk_status(chk_status), .err_byte(err_byte),
    .err_bit(err_bit)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;
  logic [7:0]  blk [256];
  logic [20:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference parity written from R1/R2
  function automatic logic [20:0] model_raw();
    logic [7:0] lo8 = '0, hi8 = '0;
    logic [2:0] c0 = '0, c1 = '0;
    logic [20:0] r;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 8; j++)
        if (blk[i][j]) begin
          for (int k = 0; k < 8; k++)
            if (((i >> k) & 1) == 1) hi8[k] = ~hi8[k]; else lo8[k] = ~lo8[k];
          for (int m = 0; m < 3; m++)
            if (((j >> m) & 1) == 1) c1[m] = ~c1[m]; else c0[m] = ~c0[m];
        end
    for (int m = 0; m < 3; m++) begin r[2*m] = c0[m]; r[2*m+1] = c1[m]; end
    for (int k = 0; k < 7; k++) begin r[6+2*k] = lo8[k]; r[7+2*k] = hi8[k]; end
    r[20] = lo8[7];
    return r;
  endfunction

  function automatic logic [23:0] model_code(input logic [20:0] r);
    logic [23:0] s = {3'b000, r} << 2;
    return ~s;
  endfunction

  task automatic put_byte(input logic [7:0] d, input logic en);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; ecc_en = en;
  endtask

  // R4 R5 R12: stream one block; optional gaps, disabled junk, collision
  task automatic send_block(input bit gaps, input bit junk, input bit collide,
                            input logic [23:0] ccode);
    for (int i = 0; i < 256; i++) begin
      if (junk && i == 100)
        for (int g = 0; g < 50; g++) put_byte(8'(g * 13 + 7), 1'b0);
      if (gaps && (i % 7) == 3) begin
        @(negedge clk); in_valid = 1'b0;
      end
      if (i == 255) exp_q.push_back(model_raw());
      put_byte(blk[i], 1'b1);
      if (collide && i == 255) begin chk_valid = 1'b1; chk_code = ccode; end
    end
    @(negedge clk);
    in_valid = 1'b0; chk_valid = 1'b0;
    if (collide) begin
      check(chk_done === 1'b1, "R12", "chk_done at collision", 32'(chk_done), 1);
      check(chk_status === 2'd0, "R12", "collision uses old parity", 32'(chk_status), 0);
    end
  endtask

  task automatic do_chk(input logic [23:0] code, input logic [1:0] st,
                        input logic [7:0] b, input logic [2:0] j, input string req);
    @(negedge clk);
    chk_valid = 1'b1; chk_code = code;
    @(negedge clk);
    chk_valid = 1'b0;
    check(chk_done === 1'b1, req, "chk_done", 32'(chk_done), 1);
    check(chk_status === st, req, "chk_status", 32'(chk_status), 32'(st));
    check(err_byte === b, req, "err_byte", 32'(err_byte), 32'(b));
    check(err_bit === j, req, "err_bit", 32'(err_bit), 32'(j));
  endtask

  // scoreboard monitor: R1 R2 R3 R4 R6
  always @(negedge clk) begin
    if (!rst && blk_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected blk_done", 1, 0);
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        check(raw_par === e, "R1", "raw_par", 32'(raw_par), 32'(e));
        check(raw_par[5:0] === e[5:0], "R2", "column parity", 32'(raw_par[5:0]), 32'(e[5:0]));
        check(code_out === model_code(e), "R3", "code_out", 32'(code_out), 32'(model_code(e)));
        check(par_ready === 1'b1, "R6", "par_ready with done", 32'(par_ready), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] clean_code, code_a;
    rst = 1'b1; ecc_en = 1'b0; ecc_clr = 1'b0; in_valid = 1'b0;
    in_data = '0; chk_valid = 1'b0; chk_code = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    check(raw_par === '0, "R11", "raw_par after reset", 32'(raw_par), 0);
    check(code_out === 24'hFFFFFF, "R11", "code_out after reset", 32'(code_out), 32'hFFFFFF);
    check(par_ready === 1'b0, "R11", "par_ready after reset", 32'(par_ready), 0);
    check(blk_done === 1'b0 && chk_done === 1'b0, "R11", "pulses after reset", 32'(blk_done), 0);
    check(in_ready === 1'b1, "R11", "in_ready after reset", 32'(in_ready), 1);

    for (int i = 0; i < 256; i++) blk[i] = 8'h00;
    send_block(0, 0, 0, '0);
    for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
    send_block(0, 0, 0, '0);
    for (int i = 0; i < 256; i++) blk[i] = (i == 8'h80) ? 8'h01 : 8'h00;
    send_block(0, 0, 0, '0);
    for (int i = 0; i < 256; i++) blk[i] = 8'(i);
    send_block(1, 0, 0, '0);
    for (int i = 0; i < 256; i++) blk[i] = 8'((i * 37 + 11) ^ (i >> 3));
    send_block(0, 0, 0, '0);
    send_block(0, 1, 0, '0);      // R5: junk with ecc_en low
    // R7: clean compare
    clean_code = model_code(model_raw());
    do_chk(clean_code, 2'd0, 8'd0, 3'd0, "R7");

    // R8: single data bit flip at byte 0xB5 bit 6
    blk[8'hB5][6] = ~blk[8'hB5][6];
    send_block(0, 0, 0, '0);
    do_chk(clean_code, 2'd1, 8'hB5, 3'd6, "R8");
    blk[8'hB5][6] = ~blk[8'hB5][6];
    // R8: byte 0x2A bit 1 (index bit 7 clear)
    blk[8'h2A][1] = ~blk[8'h2A][1];
    send_block(0, 0, 0, '0);
    do_chk(clean_code, 2'd1, 8'h2A, 3'd1, "R8");
    blk[8'h2A][1] = ~blk[8'h2A][1];
    // R10: two data bits in different bytes
    blk[3][1] = ~blk[3][1];
    blk[200][6] = ~blk[200][6];
    send_block(0, 0, 0, '0);
    do_chk(clean_code, 2'd3, 8'd0, 3'd0, "R10");
    blk[3][1] = ~blk[3][1];
    blk[200][6] = ~blk[200][6];

    // R9: clean data, one flipped code bit inside and outside the field
    send_block(0, 0, 0, '0);
    do_chk(clean_code ^ 24'h000200, 2'd2, 8'd0, 3'd0, "R9");
    do_chk(clean_code ^ 24'h800000, 2'd2, 8'd0, 3'd0, "R9");
    // R10: both bits of one pair flipped in the code
    do_chk(clean_code ^ 24'h00000C, 2'd3, 8'd0, 3'd0, "R10");

    // R6: clear mid-block, byte offered during clear is refused
    for (int i = 0; i < 80; i++) put_byte(8'(i * 3 + 1), 1'b1);
    @(negedge clk);
    ecc_clr = 1'b1; in_valid = 1'b1; in_data = 8'hA5; ecc_en = 1'b1;
    #1;
    check(in_ready === 1'b0, "R6", "in_ready during clear", 32'(in_ready), 0);
    @(negedge clk);
    ecc_clr = 1'b0; in_valid = 1'b0;
    check(par_ready === 1'b0, "R6", "par_ready after clear", 32'(par_ready), 0);
    for (int i = 0; i < 256; i++) blk[i] = 8'(255 - i);
    send_block(0, 0, 0, '0);

    // R12: compare in the same cycle as the next block's last byte
    code_a = model_code(model_raw());
    for (int i = 0; i < 256; i++) blk[i] = 8'((i * 91) ^ 8'h5C);
    send_block(0, 0, 1, code_a);
    do_chk(model_code(model_raw()), 2'd0, 8'd0, 3'd0, "R7");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "blocks left unseen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule